// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges several reset requests into one active-low reset output with a stretched release. Two voltage-good flags arrive as synchronous logic: a primary supply flag and a secondary monitored-voltage flag. An asynchronous active-low manual reset pin is brought into the clock domain and filtered. A one-cycle fault request from a watchdog asks for a reset pulse. The output stays low while any level condition is active. It is released only after a programmable number of clock cycles has passed with every condition clear.

The controller is a four-state machine:
- `ST_HOLD`: a level condition is present, or the logic has just come out of reset.
- `ST_RELEASE`: counting down the timeout after every level condition has cleared.
- `ST_WDOG`: counting down a watchdog-requested pulse.
- `ST_IDLE`: the reset output is high.

The transitions are:
- HOLD→RELEASE when all conditions clear.
- RELEASE→HOLD and WDOG→HOLD when a condition returns.
- IDLE→HOLD when a condition appears.
- IDLE→WDOG, RELEASE→WDOG and WDOG→WDOG on a watchdog request, each of which reloads the count.
- RELEASE→IDLE and WDOG→IDLE when the count expires.

A cause output records the source that started the most recent assertion.

Top module: `supv_reset_gen`

## Requirements
- R1: When `supply_ok_i` is low at a rising edge, `rst_n_o` is low after that edge and stays low while the flag is low.
- R2: With `MON_EN` nonzero (the default), a low `mon_ok_i` asserts reset in the same way as R1. Either flag alone is enough.
- R3: When `mr_n_i` is held low for `MR_QUAL_CYC` cycles, reset asserts. If `mr_n_i` is driven low just before edge A, `rst_n_o` first reads low after edge A+`MR_QUAL_CYC`+2.
- R4: A low pulse on `mr_n_i` shorter than `MR_QUAL_CYC` cycles does not assert reset and does not change `cause_o`. This includes pulses shorter than `MR_GLITCH_CYC`. After a qualified press, the pin must read high for `MR_GLITCH_CYC` filtered samples before the press counts as released.
- R5: Once every level condition is clear at edge E, `rst_n_o` goes high after edge E+T. T is the value of `timeout_i`.
- R6: If a level condition returns while the release count is running, the count is abandoned. A full T cycles is counted again after the condition clears.
- R7: A one-cycle `wd_fault_i` seen at edge E0 while the output is high drives `rst_n_o` low from E0 to E0+T, exactly T cycles.
- R8: A watchdog request while a level condition holds reset has no effect on the release timing. A watchdog request during a release or watchdog count reloads the count to a full T cycles.
- R9: While `arst_n` is low, `rst_n_o` is low and `cause_o` is 0. After `arst_n` is released, `rst_n_o` goes high after the (T+1)th rising edge, provided no condition is present.
- R10: `cause_o` is updated only when the output leaves the high state, and is then held until the next such event. Its encoding is 0 none, 1 supply, 2 monitor, 3 manual, 4 watchdog. When several sources start together the priority is supply, then monitor, then manual, then watchdog.
- R11: `timeout_i` is sampled when each count starts. A value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset of the logic |
| supply_ok_i | input | 1 | Primary supply above threshold (1 = good) |
| mon_ok_i | input | 1 | Secondary monitored voltage above threshold (1 = good) |
| mr_n_i | input | 1 | Asynchronous manual reset, active low |
| wd_fault_i | input | 1 | Watchdog fault request, one cycle high |
| timeout_i | input | TMO_W | Release timeout in clock cycles |
| rst_n_o | output | 1 | Reset output, active low |
| cause_o | output | 3 | Source of the most recent assertion |

## Verification
The supply and monitor flags act at the next rising edge. The watchdog request also lowers the output at the next edge. The manual pin costs two synchronizer stages plus one filter register, so its assertion appears `MR_QUAL_CYC`+2 edges after the first low edge. Its release adds `MR_GLITCH_CYC`+2 edges before the T-cycle count.

The bench drives inputs on falling edges and samples outputs on falling edges. A sample taken k falling edges after a stimulus therefore reflects rising edge k-1 after it. Every release is measured by counting the falling-edge samples at which the output is still low, and each count is compared with a total computed from the figures above.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RELEASE = 2'd1,
        ST_WDOG    = 2'd2,
        ST_IDLE    = 2'd3
    } supv_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_SUPPLY  = 3'd1,
        CAUSE_MONITOR = 3'd2,
        CAUSE_MANUAL  = 3'd3,
        CAUSE_WDOG    = 3'd4
    } supv_cause_e;

endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
    parameter int GLITCH_CYC = 4,
    parameter int QUAL_CYC   = 40
) (
    input  logic clk,
    input  logic arst_n,
    input  logic s_n_i,
    output logic act_o
);
    localparam int LW = $clog2(QUAL_CYC + 1);
    localparam int HW = $clog2(GLITCH_CYC + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(QUAL_CYC - 1);
    localparam logic [HW-1:0] HI_LAST  = HW'(GLITCH_CYC - 1);

    logic [LW-1:0] low_cnt;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
            act_o   <= 1'b0;
        end else if (!s_n_i) begin
            hi_cnt <= '0;
            if (low_cnt != LOW_LAST) low_cnt <= low_cnt + 1'b1;
            if (low_cnt == LOW_LAST) act_o <= 1'b1;
        end else begin
            low_cnt <= '0;
            if (hi_cnt != HI_LAST) hi_cnt <= hi_cnt + 1'b1;
            if (hi_cnt == HI_LAST) act_o <= 1'b0;
        end
    end

    initial begin
        assert (QUAL_CYC >= GLITCH_CYC && GLITCH_CYC >= 1)
            else $error("filter widths out of range");
    end

    // R4: a press is recognised only while the synchronised pin is low
    a_r4_rise_needs_low: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(act_o) |-> $past(!s_n_i));
    // R4: a press is dropped only while the synchronised pin is high
    a_r4_fall_needs_high: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(act_o) |-> $past(s_n_i));
endmodule

// File: rtl/supv_timer.sv
module supv_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    input  logic         en_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] load_val;

    always_comb load_val = (len_i == '0) ? '0 : len_i - 1'b1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                    cnt_q <= '0;
        else if (load_i)                cnt_q <= load_val;
        else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    always_comb done_o = (cnt_q == '0);

    // R5: without a reload the count never grows
    a_r5_count_down_only: assert property (@(posedge clk) disable iff (!arst_n)
        !load_i |=> cnt_q <= $past(cnt_q));
    // R11: a reload never exceeds the requested length
    a_r11_load_bound: assert property (@(posedge clk) disable iff (!arst_n)
        load_i |=> (cnt_q < $past(len_i)) || (cnt_q == '0));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int TMO_W         = 16,
    parameter int MR_GLITCH_CYC = 4,
    parameter int MR_QUAL_CYC   = 40,
    parameter int MON_EN        = 1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             supply_ok_i,
    input  logic             mon_ok_i,
    input  logic             mr_n_i,
    input  logic             wd_fault_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             rst_n_o,
    output logic [2:0]       cause_o
);
    supv_state_e state, state_nxt;
    supv_cause_e cause_q, cause_nxt;

    logic mr_sync_n;
    logic mr_act;
    logic sup_low;
    logic mon_low;
    logic cond_any;
    logic tmr_load;
    logic tmr_en;
    logic tmr_done;

    supv_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    (mr_n_i),
        .q_o    (mr_sync_n)
    );

    supv_mr_filter #(
        .GLITCH_CYC (MR_GLITCH_CYC),
        .QUAL_CYC   (MR_QUAL_CYC)
    ) u_mr_filt (
        .clk    (clk),
        .arst_n (arst_n),
        .s_n_i  (mr_sync_n),
        .act_o  (mr_act)
    );

    supv_timer #(.W(TMO_W)) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .load_i (tmr_load),
        .len_i  (timeout_i),
        .en_i   (tmr_en),
        .done_o (tmr_done)
    );

    always_comb sup_low = !supply_ok_i;

    generate
        if (MON_EN != 0) begin : g_mon
            always_comb mon_low = !mon_ok_i;
            // R2: a low monitor flag forces reset at the next edge
            a_r2_monitor_asserts: assert property (@(posedge clk) disable iff (!arst_n)
                !mon_ok_i |=> !rst_n_o);
        end else begin : g_nomon
            logic unused_mon;
            always_comb unused_mon = mon_ok_i;
            always_comb mon_low = 1'b0;
        end
    endgenerate

    always_comb cond_any = sup_low || mon_low || mr_act;

    // next state and timer control
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        unique case (state)
            ST_HOLD: begin
                if (!cond_any) begin
                    state_nxt = ST_RELEASE;
                    tmr_load  = 1'b1;
                end
            end
            ST_RELEASE, ST_WDOG: begin
                if (cond_any) begin
                    state_nxt = ST_HOLD;
                end else if (wd_fault_i) begin
                    state_nxt = ST_WDOG;
                    tmr_load  = 1'b1;
                end else if (tmr_done) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (cond_any) begin
                    state_nxt = ST_HOLD;
                end else if (wd_fault_i) begin
                    state_nxt = ST_WDOG;
                    tmr_load  = 1'b1;
                end
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    always_comb tmr_en = (state == ST_RELEASE) || (state == ST_WDOG);

    always_comb begin
        if (sup_low)         cause_nxt = CAUSE_SUPPLY;
        else if (mon_low)    cause_nxt = CAUSE_MONITOR;
        else if (mr_act)     cause_nxt = CAUSE_MANUAL;
        else if (wd_fault_i) cause_nxt = CAUSE_WDOG;
        else                 cause_nxt = CAUSE_NONE;
    end

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_HOLD;
        else         state <= state_nxt;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                                    cause_q <= CAUSE_NONE;
        else if (state == ST_IDLE && state_nxt != ST_IDLE) cause_q <= cause_nxt;
    end

    // outputs
    always_comb begin
        rst_n_o = (state == ST_IDLE);
        cause_o = cause_q;
    end

    // R1: a low supply flag forces reset at the next edge
    a_r1_supply_asserts: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok_i |=> !rst_n_o);
    // R7: a watchdog request while released lowers the output
    a_r7_wd_pulse_starts: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_n_o && wd_fault_i) |=> !rst_n_o);
    // R5: release only when the timer has expired
    a_r5_release_on_done: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_o) |-> $past(tmr_done));
    // R10: every new assertion records a source
    a_r10_cause_recorded: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_n_o) |-> cause_o != 3'd0);
    // R10: the cause is held while the output stays high
    a_r10_cause_held: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_n_o && $past(rst_n_o)) |-> $stable(cause_o));
endmodule

// File: tb/supv_reset_gen_test.sv
module supv_reset_gen_test;
    localparam int GL = 4;
    localparam int QL = 40;

    typedef struct packed {
        logic        sup;
        logic        mon;
        logic        wd;
        logic [7:0]  hold;
        logic [15:0] tmo;
        logic [2:0]  cause;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'd3, 16'd5,  3'd1},
        '{1'b1, 1'b0, 1'b0, 8'd1, 16'd1,  3'd2},
        '{1'b0, 1'b0, 1'b0, 8'd4, 16'd7,  3'd1},
        '{1'b1, 1'b1, 1'b1, 8'd1, 16'd6,  3'd4},
        '{1'b0, 1'b1, 1'b0, 8'd2, 16'd0,  3'd1},
        '{1'b1, 1'b1, 1'b1, 8'd1, 16'd1,  3'd4},
        '{1'b1, 1'b0, 1'b0, 8'd6, 16'd17, 3'd2},
        '{1'b1, 1'b1, 1'b1, 8'd1, 16'd0,  3'd4}
    };

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        supply_ok = 1'b1;
    logic        mon_ok = 1'b1;
    logic        mr_n = 1'b1;
    logic        wd_fault = 1'b0;
    logic [15:0] timeout = 16'd10;
    logic        rst_n;
    logic [2:0]  cause;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    supv_reset_gen #(
        .TMO_W(16), .MR_GLITCH_CYC(GL), .MR_QUAL_CYC(QL), .MON_EN(1)
    ) uut (
        .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok), .mon_ok_i(mon_ok),
        .mr_n_i(mr_n), .wd_fault_i(wd_fault), .timeout_i(timeout),
        .rst_n_o(rst_n), .cause_o(cause)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        @(negedge clk);
        while (!rst_n) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (!rst_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int eff;
        logic seen_low;

        // R9: reset state
        #1;
        chk(rst_n == 1'b0, "R9 reset level", rst_n, 0);
        chk(cause == 3'd0, "R10 reset cause", cause, 0);
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        count_low(n);
        chk(n == 10, "R9 first release length", n, 10);
        chk(cause == 3'd0, "R10 cause before any event", cause, 0);

        // vector table: R1 R2 R5 R7 R10 R11
        for (int i = 0; i < NV; i++) begin
            wait_idle();
            eff = (VECS[i].tmo == 16'd0) ? 1 : int'(VECS[i].tmo);
            timeout   = VECS[i].tmo;
            supply_ok = VECS[i].sup;
            mon_ok    = VECS[i].mon;
            wd_fault  = VECS[i].wd;
            @(negedge clk);
            chk(rst_n == 1'b0, "R1/R2/R7 assert next edge", rst_n, 0);
            chk(cause == VECS[i].cause, "R10 cause value", cause, int'(VECS[i].cause));
            if (VECS[i].wd) begin
                wd_fault = 1'b0;
                count_low(n);
                chk(n == eff - 1, "R7/R11 watchdog pulse length", n + 1, eff);
            end else begin
                repeat (int'(VECS[i].hold) - 1) @(negedge clk);
                supply_ok = 1'b1;
                mon_ok    = 1'b1;
                count_low(n);
                chk(n == eff, "R5/R11 release length", n, eff);
            end
            chk(cause == VECS[i].cause, "R10 cause retained", cause, int'(VECS[i].cause));
        end

        // R6: condition returns during the release count
        wait_idle();
        timeout = 16'd12;
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (5) @(negedge clk);
        chk(rst_n == 1'b0, "R6 still counting", rst_n, 0);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        count_low(n);
        chk(n == 12, "R6 full restart", n, 12);

        // R8: watchdog while a level condition holds
        wait_idle();
        timeout = 16'd9;
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        wd_fault = 1'b1;
        @(negedge clk);
        wd_fault = 1'b0;
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        count_low(n);
        chk(n == 9, "R8 watchdog ignored during hold", n, 9);
        chk(cause == 3'd1, "R8 cause unchanged", cause, 1);

        // R8: watchdog during a watchdog pulse reloads
        wait_idle();
        wd_fault = 1'b1;
        @(negedge clk);
        wd_fault = 1'b0;
        repeat (3) @(negedge clk);
        wd_fault = 1'b1;
        @(negedge clk);
        wd_fault = 1'b0;
        count_low(n);
        chk(n == 8, "R8 watchdog reload", n + 1, 9);

        // R4: short manual glitches are ignored
        wait_idle();
        seen_low = 1'b0;
        mr_n = 1'b0;
        repeat (GL - 1) @(negedge clk);
        mr_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (!rst_n) seen_low = 1'b1;
        end
        chk(seen_low == 1'b0, "R4 glitch below reject width", seen_low, 0);
        mr_n = 1'b0;
        repeat (QL - 1) begin
            @(negedge clk);
            if (!rst_n) seen_low = 1'b1;
        end
        mr_n = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (!rst_n) seen_low = 1'b1;
        end
        chk(seen_low == 1'b0, "R4 press below qualify width", seen_low, 0);
        chk(cause == 3'd4, "R4 cause untouched", cause, 4);

        // R3: qualified manual press, exact latency and release
        timeout = 16'd8;
        mr_n = 1'b0;
        repeat (QL + 2) @(negedge clk);
        chk(rst_n == 1'b1, "R3 not yet asserted", rst_n, 1);
        @(negedge clk);
        chk(rst_n == 1'b0, "R3 asserted on time", rst_n, 0);
        chk(cause == 3'd3, "R10 manual cause", cause, 3);
        repeat (10) @(negedge clk);
        mr_n = 1'b1;
        count_low(n);
        chk(n == GL + 8 + 2, "R3/R4 manual release length", n, GL + 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule